// File: doc/BRIEF.md
# Load/Store Address Gate

This block sits between instruction decode and the data memory port of a processor pipeline. For each load or store request it forms the effective address from a base register value and an offset (taken from a register or an immediate). A register offset may be scaled by the access size. The block then decides whether the access may go ahead. It also produces the byte-lane enables and the word-aligned address, or addresses, that the memory side needs.

Two checks guard each request. A user-space access issued outside supervisor mode is refused with a privilege fault. A 2-, 4- or 8-byte access whose address is not a multiple of its size is refused with a misalignment fault. The privilege check wins when both apply. Every result is registered and appears exactly one cycle after the request. Each response carries exactly one of three outcomes: go, privilege fault or misalignment fault.

Top module: `lsu_addr_gate`

## Requirements
- R1: With an immediate offset, or a register offset without scaling, the effective address is base plus offset, computed in 32 bits and wrapping modulo 2^32.
- R2: With a register offset and the scale flag set, the offset is multiplied by the access size before the add. The size code is 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The scale flag has no effect on an immediate offset.
- R3: A byte access (size code 0) is never misaligned. It gets go whenever it is not refused for privilege.
- R4: A 2-, 4- or 8-byte access whose effective address has any of its low 1, 2 or 3 bits set, respectively, gets a misalignment fault and no go.
- R5: A user-space access (user flag 1) with the supervisor input low gets a privilege fault and no go. With supervisor high, the same access proceeds like an ordinary one.
- R6: When a request is both refused for privilege and misaligned, only the privilege fault is raised.
- R7: For a byte access the lane mask is a single bit at position 3 minus address bits [1:0], so byte offset 0 drives lane bit 3.
- R8: For a halfword access the lane mask is 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. Word and doubleword accesses give 4'b1111.
- R9: The word address is the effective address with bits [1:0] cleared. For a doubleword the second word address is the word address plus 4 and the doubleword flag is 1. Otherwise the second address equals the word address and the flag is 0.
- R10: Every response appears one cycle after a valid request:
  - the response-valid output is high for that cycle only;
  - exactly one of go, privilege fault or misalignment fault is high;
  - the load/store indicator is echoed back.
  In cycles with no response, go and both faults are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_base | input | 32 | Base register value |
| req_offset | input | 32 | Offset register value or immediate |
| req_ofs_is_reg | input | 1 | Offset comes from a register |
| req_ofs_scaled | input | 1 | Scale a register offset by the access size |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_user_acc | input | 1 | User-space access variant |
| req_supervisor | input | 1 | Processor is in supervisor mode |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_is_store | output | 1 | Echo of the load/store indicator |
| rsp_go | output | 1 | Access may proceed |
| rsp_priv_fault | output | 1 | Privilege violation |
| rsp_misalign_fault | output | 1 | Misaligned access |
| rsp_eff_addr | output | 32 | Effective address |
| rsp_lane_en | output | 4 | Byte-lane enables |
| rsp_word_addr | output | 32 | Word-aligned address |
| rsp_word2_addr | output | 32 | Second word address of a doubleword |
| rsp_is_double | output | 1 | Doubleword access |

## Verification
Every result (address, lanes, outcome, echo) is due on the clock edge that follows the request edge. The bench drives a request on a falling edge and computes its expected response at that moment. It compares all outputs on the next falling edge, one full cycle later and half a cycle clear of any edge. Idle cycles are compared the same way against an all-quiet response. Back-to-back requests therefore check that each response belongs to its own request.

// File: rtl/lsu_gate_pkg.sv
package lsu_gate_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE   = 2'd0,
      SZ_HALF   = 2'd1,
      SZ_WORD   = 2'd2,
      SZ_DOUBLE = 2'd3
   } lsu_size_e;

   // low-address-bit mask that must be zero for an access of this size
   function automatic logic [2:0] align_mask(lsu_size_e sz);
      logic [2:0] m;
      case (sz)
         SZ_BYTE:   m = 3'b000;
         SZ_HALF:   m = 3'b001;
         SZ_WORD:   m = 3'b011;
         default:   m = 3'b111;
      endcase
      return m;
   endfunction

   typedef struct packed {
      logic go;
      logic priv;
      logic misal;
   } lsu_verdict_t;

endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder
   import lsu_gate_pkg::*;
#(
   parameter int AW            = 32,
   parameter bit SCALE_SUPPORT = 1'b1
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] offset_i,
   input  logic          ofs_is_reg_i,
   input  logic          ofs_scaled_i,
   input  lsu_size_e     size_i,
   output logic [AW-1:0] ea_o
);

   logic [AW-1:0] eff_ofs;

   generate
      if (SCALE_SUPPORT) begin : g_scaled
         // scaling by 1,2,4,8 is a left shift by the size code
         always_comb begin
            if (ofs_is_reg_i && ofs_scaled_i)
               eff_ofs = offset_i << size_i;
            else
               eff_ofs = offset_i;
         end
      end else begin : g_plain
         logic unused_scale;
         assign unused_scale = ofs_is_reg_i ^ ofs_scaled_i ^ (^size_i);
         assign eff_ofs = offset_i;
      end
   endgenerate

   assign ea_o = base_i + eff_ofs;

endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
   import lsu_gate_pkg::*;
#(
   parameter int WORD_BYTES = 4,
   localparam int OFS_W     = $clog2(WORD_BYTES)
) (
   input  logic [OFS_W-1:0]      byte_ofs_i,
   input  lsu_size_e             size_i,
   output logic [WORD_BYTES-1:0] lane_o
);

   localparam int PAIRS = WORD_BYTES / 2;

   // byte offset 0 drives the most significant lane
   generate
      for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
         localparam int BYTE_HIT = WORD_BYTES - 1 - i;
         localparam int PAIR_HIT = PAIRS - 1 - (i / 2);
         always_comb begin
            case (size_i)
               SZ_BYTE: lane_o[i] = (int'(byte_ofs_i) == BYTE_HIT);
               SZ_HALF: lane_o[i] = (int'(byte_ofs_i >> 1) == PAIR_HIT);
               default: lane_o[i] = 1'b1;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/lsu_access_judge.sv
module lsu_access_judge
   import lsu_gate_pkg::*;
(
   input  logic [2:0]   ea_lo_i,
   input  lsu_size_e    size_i,
   input  logic         user_acc_i,
   input  logic         supervisor_i,
   output lsu_verdict_t verdict_o
);

   logic refused;
   logic odd_addr;

   assign refused  = user_acc_i & ~supervisor_i;
   assign odd_addr = |(ea_lo_i & align_mask(size_i));

   // privilege outranks alignment
   always_comb begin
      verdict_o.priv  = refused;
      verdict_o.misal = ~refused & odd_addr;
      verdict_o.go    = ~refused & ~odd_addr;
   end

endmodule

// File: rtl/lsu_addr_gate.sv
module lsu_addr_gate
   import lsu_gate_pkg::*;
#(
   parameter int AW            = 32,
   parameter int WORD_BYTES    = 4,
   parameter bit SCALE_SUPPORT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_is_store,
   input  logic [AW-1:0]         req_base,
   input  logic [AW-1:0]         req_offset,
   input  logic                  req_ofs_is_reg,
   input  logic                  req_ofs_scaled,
   input  logic [1:0]            req_size,
   input  logic                  req_user_acc,
   input  logic                  req_supervisor,
   output logic                  rsp_valid,
   output logic                  rsp_is_store,
   output logic                  rsp_go,
   output logic                  rsp_priv_fault,
   output logic                  rsp_misalign_fault,
   output logic [AW-1:0]         rsp_eff_addr,
   output logic [WORD_BYTES-1:0] rsp_lane_en,
   output logic [AW-1:0]         rsp_word_addr,
   output logic [AW-1:0]         rsp_word2_addr,
   output logic                  rsp_is_double
);

   localparam int OFS_W = $clog2(WORD_BYTES);

   generate
      if (WORD_BYTES < 4 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two of at least 4");
      end
      if (AW < 8) begin : g_bad_aw
         $error("AW must be at least 8");
      end
   endgenerate

   lsu_size_e    size_e;
   logic [AW-1:0] ea;
   logic [WORD_BYTES-1:0] lanes;
   lsu_verdict_t verdict;
   logic [AW-1:0] word_a;

   assign size_e = lsu_size_e'(req_size);

   lsu_ea_adder #(.AW(AW), .SCALE_SUPPORT(SCALE_SUPPORT)) u_adder (
      .base_i       (req_base),
      .offset_i     (req_offset),
      .ofs_is_reg_i (req_ofs_is_reg),
      .ofs_scaled_i (req_ofs_scaled),
      .size_i       (size_e),
      .ea_o         (ea)
   );

   lsu_lane_map #(.WORD_BYTES(WORD_BYTES)) u_lanes (
      .byte_ofs_i (ea[OFS_W-1:0]),
      .size_i     (size_e),
      .lane_o     (lanes)
   );

   lsu_access_judge u_judge (
      .ea_lo_i      (ea[2:0]),
      .size_i       (size_e),
      .user_acc_i   (req_user_acc),
      .supervisor_i (req_supervisor),
      .verdict_o    (verdict)
   );

   assign word_a = {ea[AW-1:OFS_W], {OFS_W{1'b0}}};

   // outcome flags: one pulse per request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid          <= 1'b0;
         rsp_go             <= 1'b0;
         rsp_priv_fault     <= 1'b0;
         rsp_misalign_fault <= 1'b0;
      end else begin
         rsp_valid          <= req_valid;
         rsp_go             <= req_valid & verdict.go;
         rsp_priv_fault     <= req_valid & verdict.priv;
         rsp_misalign_fault <= req_valid & verdict.misal;
      end
   end

   // payload: captured on each request, held otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_is_store   <= 1'b0;
         rsp_eff_addr   <= '0;
         rsp_lane_en    <= '0;
         rsp_word_addr  <= '0;
         rsp_word2_addr <= '0;
         rsp_is_double  <= 1'b0;
      end else if (req_valid) begin
         rsp_is_store   <= req_is_store;
         rsp_eff_addr   <= ea;
         rsp_lane_en    <= lanes;
         rsp_word_addr  <= word_a;
         rsp_word2_addr <= (size_e == SZ_DOUBLE) ? word_a + AW'(WORD_BYTES) : word_a;
         rsp_is_double  <= (size_e == SZ_DOUBLE);
      end
   end

   // ---------------- assertions ----------------
   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_go, rsp_priv_fault, rsp_misalign_fault}));

   p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_go || rsp_priv_fault || rsp_misalign_fault));

   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_refuse_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user_acc && !req_supervisor) |=> rsp_priv_fault);

   p_priv_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user_acc && !req_supervisor) |=> !rsp_misalign_fault);

   p_byte_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0 && !(req_user_acc && !req_supervisor)) |=> rsp_go);

   p_word_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_word_addr[OFS_W-1:0] == '0));

   p_double_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_is_double) |-> (rsp_word2_addr - rsp_word_addr == AW'(WORD_BYTES)));

   p_lanes_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_lane_en != '0));

endmodule

// File: tb/tb_lsu_addr_gate.sv
`timescale 1ns/1ps
module tb_lsu_addr_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_is_store = 1'b0;
   logic [31:0] req_base = '0, req_offset = '0;
   logic        req_ofs_is_reg = 1'b0, req_ofs_scaled = 1'b0;
   logic [1:0]  req_size = '0;
   logic        req_user_acc = 1'b0, req_supervisor = 1'b0;
   logic        rsp_valid, rsp_is_store, rsp_go, rsp_priv_fault, rsp_misalign_fault;
   logic [31:0] rsp_eff_addr, rsp_word_addr, rsp_word2_addr;
   logic [3:0]  rsp_lane_en;
   logic        rsp_is_double;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #10 clk = ~clk;  // 50 MHz

   lsu_addr_gate dut (
      .clk, .rst_n, .req_valid, .req_is_store, .req_base, .req_offset,
      .req_ofs_is_reg, .req_ofs_scaled, .req_size, .req_user_acc, .req_supervisor,
      .rsp_valid, .rsp_is_store, .rsp_go, .rsp_priv_fault, .rsp_misalign_fault,
      .rsp_eff_addr, .rsp_lane_en, .rsp_word_addr, .rsp_word2_addr, .rsp_is_double
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: computes the expected response of one request
   task automatic send(input bit st, input logic [31:0] b, input logic [31:0] o,
                       input bit isreg, input bit scl, input int szc,
                       input bit usr, input bit sup);
      longint unsigned nbytes, ofs_val, ea_full;
      logic [31:0] e_ea, e_wa, e_w2;
      logic [3:0]  e_lane;
      bit          e_priv, e_mis, e_go;
      string       t_ea, t_out, t_lane;
      nbytes  = 64'd1 << szc;
      ofs_val = (isreg && scl) ? longint'(o) * nbytes : longint'(o);
      ea_full = (longint'(b) + ofs_val) % 64'h1_0000_0000;
      e_ea    = ea_full[31:0];
      e_priv  = usr && !sup;
      e_mis   = !e_priv && ((ea_full % nbytes) != 0);
      e_go    = !e_priv && !e_mis;
      case (szc)
         0: e_lane = 4'b1000 >> (ea_full % 4);
         1: e_lane = ((ea_full / 2) % 2 == 0) ? 4'b1100 : 4'b0011;
         default: e_lane = 4'b1111;
      endcase
      e_wa = 32'((ea_full / 4) * 4);
      e_w2 = (szc == 3) ? e_wa + 32'd4 : e_wa;
      t_ea   = (isreg && scl) ? "R2" : "R1";
      t_out  = e_priv ? ((ea_full % nbytes != 0) ? "R6" : "R5") : (szc == 0 ? "R3" : "R4");
      t_lane = (szc == 0) ? "R7" : "R8";

      req_valid = 1'b1; req_is_store = st; req_base = b; req_offset = o;
      req_ofs_is_reg = isreg; req_ofs_scaled = scl; req_size = 2'(szc);
      req_user_acc = usr; req_supervisor = sup;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_eff_addr == e_ea, t_ea, "effective address", 64'(rsp_eff_addr), 64'(e_ea));
      check({rsp_go, rsp_priv_fault, rsp_misalign_fault} == {e_go, e_priv, e_mis}, t_out,
            "go/priv/misalign", 64'({rsp_go, rsp_priv_fault, rsp_misalign_fault}),
            64'({e_go, e_priv, e_mis}));
      check(rsp_lane_en == e_lane, t_lane, "lane mask", 64'(rsp_lane_en), 64'(e_lane));
      check(rsp_word_addr == e_wa && rsp_word2_addr == e_w2 && rsp_is_double == (szc == 3),
            "R9", "word addresses", {rsp_word_addr, rsp_word2_addr}, {e_wa, e_w2});
      check(rsp_valid && rsp_is_store == st, "R10", "valid/store echo",
            64'({rsp_valid, rsp_is_store}), 64'({1'b1, st}));
   endtask

   task automatic idle_check();
      @(negedge clk);
      check(!rsp_valid && !rsp_go && !rsp_priv_fault && !rsp_misalign_fault, "R10",
            "idle quiet", 64'({rsp_valid, rsp_go, rsp_priv_fault, rsp_misalign_fault}), 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(!rsp_valid && !rsp_go && rsp_eff_addr == 0 && rsp_lane_en == 0, "R10",
            "reset state", 64'({rsp_valid, rsp_go, rsp_lane_en}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_check();

      // R1: plain add and wrap
      send(0, 32'h0000_1000, 32'h24, 0, 0, 2, 0, 1);
      send(1, 32'hFFFF_FFF8, 32'h10, 1, 0, 2, 0, 0);
      // R2: scaled register offset, immediate ignores scale
      send(0, 32'h0000_2000, 32'd3, 1, 1, 2, 0, 0);
      send(1, 32'h0000_2000, 32'd5, 1, 1, 3, 0, 0);
      send(0, 32'h0000_2000, 32'd5, 1, 1, 1, 0, 0);
      send(0, 32'h0000_2000, 32'd6, 0, 1, 2, 0, 0);
      send(0, 32'h8000_0000, 32'h4000_0000, 1, 1, 2, 0, 0);
      // R3 / R7: bytes at every lane
      for (int k = 0; k < 4; k++) send(0, 32'h0000_3000, 32'(k), 0, 0, 0, 0, 0);
      // R8: halves and word
      send(0, 32'h0000_3000, 32'd0, 0, 0, 1, 0, 0);
      send(0, 32'h0000_3000, 32'd2, 0, 0, 1, 0, 0);
      // R4: misaligned
      send(0, 32'h0000_3000, 32'd1, 0, 0, 1, 0, 0);
      send(0, 32'h0000_3000, 32'd2, 0, 0, 2, 0, 0);
      send(1, 32'h0000_3000, 32'd4, 0, 0, 3, 0, 0);
      send(0, 32'h0000_3000, 32'd8, 0, 0, 3, 0, 0);
      // R5: user access
      send(0, 32'h0000_4000, 32'd0, 0, 0, 2, 1, 0);
      send(1, 32'h0000_4000, 32'd0, 0, 0, 2, 1, 1);
      send(0, 32'h0000_4000, 32'd3, 0, 0, 0, 1, 0);
      // R6: privilege beats alignment
      send(0, 32'h0000_4000, 32'd6, 0, 0, 3, 1, 0);
      idle_check();
      idle_check();
      // mixed patterns, back to back
      for (int k = 0; k < 400; k++)
         send($urandom_range(0, 1), $urandom(), ($urandom_range(0, 1) != 0) ? $urandom() :
              32'($urandom_range(0, 15)), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 3), ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
      idle_check();
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule